// File: doc/BRIEF.md
# PWM Time-Base Counter Synchronizer

This block holds the time-base counters of several PWM generators (four by default) and lets software force any subset of them back to zero. Each counter counts up on a shared PWM tick enable, from zero to its own programmed period, and then wraps to zero. Software controls the block through a small 32-bit register port with an address, a write enable, write data and combinational read data.

To align counters, software writes ones into the sync register. Each one raises a request flag for the matching generator. The flag holds until the next PWM tick. On that tick the counter loads zero instead of advancing, and the flag drops on the same clock edge. Software polls the sync register, and a flag that reads zero means its reset has happened. When several flags are raised together, their counters are cleared on the same tick.

Each generator has a two-state request machine. The states are SF_IDLE and SF_PEND, with these transitions:
- SF_IDLE to SF_PEND on a write of one to the generator's sync bit (the "request" transition).
- SF_PEND to SF_IDLE on a PWM tick (the "apply" transition, which also clears the counter).
- SF_PEND stays in SF_PEND while no tick arrives, whether or not more requests are written (the "hold" transition).
- SF_IDLE stays in SF_IDLE when no request is written.

Top module: `pwm_tbase_sync`

## Requirements
- R1: After reset, the sync register at 0x04 reads zero, every counter reads zero, and every period register reads the reset period of 255.
- R2: Writing 1 to bit i of the sync register (0x04) sets flag i. The flag reads 1 until the next PWM tick. Without a tick, counter i does not change.
- R3: On the first clock edge with the PWM tick high after flag i was set, counter i loads 0 instead of incrementing, and flag i reads 0 from that same edge.
- R4: Flags set in one write clear their counters on the same tick, so afterwards those counters hold equal values.
- R5: Writing 0 to a sync bit has no effect on the flag or on the counter.
- R6: Bits 31:4 of the sync register always read 0, and writes to them affect nothing.
- R7: On each tick, a counter with no pending flag increments, or wraps to 0 once it has reached its period. Without a tick, the counter holds its value.
- R8: Writing 1 to a flag that is already pending keeps one pending reset, and the counter is cleared only once.
- R9: The period for generator i is read and written at 0x10+4*i, using its low 16 bits. Counter i reads at 0x20+4*i, zero-extended. All other addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwm_tick | input | 1 | PWM time-base advance enable |
| bus_addr | input | 8 | Byte address for reads and writes |
| bus_wr_en | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |

## Verification
A request machine stuck in SF_PEND shows up at the ports as a sync bit that still reads 1 on the first read after a tick. A flag that never rose shows up as a counter that keeps advancing past the tick that should have cleared it. Both are visible within one tick of the write. A counter cleared on the wrong edge, or cleared twice after a repeated request, appears as a counter value that is off by one or more against its neighbours on the next counter read. The bench therefore reads counters and flags right after each controlled burst of ticks.

// File: rtl/pwm_sync_pkg.sv
package pwm_sync_pkg;
    localparam int unsigned BUS_W      = 32;
    localparam int unsigned BUS_ADDR_W = 8;

    localparam logic [BUS_ADDR_W-1:0] SYNC_OFS   = 8'h04;
    localparam logic [BUS_ADDR_W-1:0] PERIOD_OFS = 8'h10;
    localparam logic [BUS_ADDR_W-1:0] COUNT_OFS  = 8'h20;

    typedef enum logic {
        SF_IDLE = 1'b0,
        SF_PEND = 1'b1
    } sync_state_e;
endpackage

// File: rtl/sync_flag.sv
module sync_flag
    import pwm_sync_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic req,
    output logic pending,
    output logic apply
);
    sync_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SF_IDLE: if (req)  state_d = SF_PEND;
            SF_PEND: if (tick) state_d = SF_IDLE;
            default:           state_d = SF_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SF_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        pending = (state_q == SF_PEND);
        apply   = (state_q == SF_PEND) && tick;
    end

    // R3
    flag_clears_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && tick) |=> !pending);
    // R2
    flag_holds_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !tick) |=> pending);
endmodule

// File: rtl/tbase_counter.sv
module tbase_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             clear,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (tick) begin
            if (clear || count >= period) count <= '0;
            else                          count <= count + 1'b1;
        end
    end

    // R7
    hold_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(count));
    // R3
    clear_loads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && clear) |=> (count == '0));
endmodule

// File: rtl/pwm_tbase_sync.sv
module pwm_tbase_sync
    import pwm_sync_pkg::*;
#(
    parameter int unsigned NUM_GEN    = 4,
    parameter int unsigned CNT_W      = 16,
    parameter int unsigned PERIOD_RST = 255
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  pwm_tick,
    input  logic [BUS_ADDR_W-1:0] bus_addr,
    input  logic                  bus_wr_en,
    input  logic [BUS_W-1:0]      bus_wdata,
    output logic [BUS_W-1:0]      bus_rdata
);
    localparam int unsigned PAD_SYNC = BUS_W - NUM_GEN;
    localparam int unsigned PAD_CNT  = BUS_W - CNT_W;

    logic [NUM_GEN-1:0] pend;
    logic [NUM_GEN-1:0] apply;
    logic [CNT_W-1:0]   period_q [NUM_GEN];
    logic [CNT_W-1:0]   count    [NUM_GEN];

    wire sync_wr = bus_wr_en && (bus_addr == SYNC_OFS);

    for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
        localparam logic [BUS_ADDR_W-1:0] PER_ADDR = PERIOD_OFS + BUS_ADDR_W'(4 * g);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                period_q[g] <= CNT_W'(PERIOD_RST);
            else if (bus_wr_en && bus_addr == PER_ADDR)
                period_q[g] <= bus_wdata[CNT_W-1:0];
        end

        sync_flag u_flag (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (pwm_tick),
            .req     (sync_wr && bus_wdata[g]),
            .pending (pend[g]),
            .apply   (apply[g])
        );

        tbase_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick   (pwm_tick),
            .clear  (apply[g]),
            .period (period_q[g]),
            .count  (count[g])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == SYNC_OFS)
            bus_rdata = {{PAD_SYNC{1'b0}}, pend};
        for (int i = 0; i < NUM_GEN; i++) begin
            if (bus_addr == PERIOD_OFS + BUS_ADDR_W'(4 * i))
                bus_rdata = {{PAD_CNT{1'b0}}, period_q[i]};
            if (bus_addr == COUNT_OFS + BUS_ADDR_W'(4 * i))
                bus_rdata = {{PAD_CNT{1'b0}}, count[i]};
        end
    end

    // R6
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == SYNC_OFS) |-> (bus_rdata[BUS_W-1:NUM_GEN] == '0));
    // R2
    request_raises_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_wr && bus_wdata[0] && !pwm_tick) |=> pend[0]);
    // R5
    zero_write_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_wr && !bus_wdata[0] && !pend[0]) |=> !pend[0]);
endmodule

// File: tb/tb_pwm_tbase_sync.sv
module tb_pwm_tbase_sync;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwm_tick = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr_en = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    pwm_tbase_sync dut (
        .clk(clk), .rst_n(rst_n), .pwm_tick(pwm_tick),
        .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic ticks(int n);
        @(negedge clk);
        pwm_tick = 1'b1;
        repeat (n) @(negedge clk);
        pwm_tick = 1'b0;
    endtask

    task automatic test_reset();
        logic [31:0] v;
        rd(8'h04, v); check("R1 sync", v, 0);
        for (int i = 0; i < 4; i++) begin
            rd(8'h20 + 8'(4*i), v); check("R1 count", v, 0);
            rd(8'h10 + 8'(4*i), v); check("R1 period", v, 255);
        end
    endtask

    task automatic test_single();
        logic [31:0] v;
        ticks(10);
        wr(8'h04, 32'h2);
        rd(8'h04, v); check("R2 flag pending", v, 2);
        rd(8'h24, v); check("R2 count held", v, 10);
        ticks(1);
        rd(8'h04, v); check("R3 flag cleared", v, 0);
        rd(8'h24, v); check("R3 count zero", v, 0);
        rd(8'h20, v); check("R7 other count", v, 11);
    endtask

    task automatic test_multi();
        logic [31:0] v;
        wr(8'h04, 32'hD);
        ticks(2);
        rd(8'h20, v); check("R4 gen0", v, 1);
        rd(8'h28, v); check("R4 gen2", v, 1);
        rd(8'h2C, v); check("R4 gen3", v, 1);
        rd(8'h24, v); check("R4 gen1 untouched", v, 2);
    endtask

    task automatic test_zero_and_reserved();
        logic [31:0] v;
        wr(8'h04, 32'h0);
        rd(8'h04, v); check("R5 no flag", v, 0);
        wr(8'h04, 32'hFFFF_FFF0);
        rd(8'h04, v); check("R6 reserved read", v, 0);
        ticks(1);
        rd(8'h20, v); check("R5 count advanced", v, 2);
        rd(8'h24, v); check("R6 count advanced", v, 3);
    endtask

    task automatic test_double();
        logic [31:0] v;
        wr(8'h04, 32'h1);
        wr(8'h04, 32'h1);
        rd(8'h04, v); check("R8 still pending", v, 1);
        ticks(1);
        rd(8'h20, v); check("R8 cleared once", v, 0);
        ticks(1);
        rd(8'h20, v); check("R8 no second clear", v, 1);
        rd(8'h04, v); check("R8 flag idle", v, 0);
    endtask

    task automatic test_wrap();
        logic [31:0] v;
        wr(8'h18, 32'h3);
        rd(8'h18, v); check("R9 period readback", v, 3);
        rd(8'h08, v); check("R9 unmapped read", v, 0);
        wr(8'h04, 32'h4);
        ticks(1);
        ticks(3);
        rd(8'h28, v); check("R7 at period", v, 3);
        ticks(1);
        rd(8'h28, v); check("R7 wrapped", v, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        test_single();
        test_multi();
        test_zero_and_reserved();
        test_double();
        test_wrap();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule